// File: doc/BRIEF.md
# Serial Peripheral Master with Switchable Queues

This block is a synchronous serial master for one slave device. It drives a serial clock, shifts 8-bit words out on a data-out line and captures 8-bit words from a data-in line, one bit per clock period. The serial clock is the system clock divided by four. The clock idles low, outgoing data changes on the falling edge, and incoming data is sampled on the rising edge.

Software reaches the block through a small register port with four word addresses. Address 0 is control, address 1 is status, a write to address 2 supplies a word to send, and a read of address 3 returns a received word and removes it. A control bit picks one of two modes. In direct mode there is exactly one word of storage in each direction. In queued mode each direction has an 8-entry first-in first-out queue. Other control bits pick the bit order, pick automatic or software-forced chip select, and enable the two interrupt outputs.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control register reads 0x0040, the status register reads 0x0001, `spi_cs_n` is high, `spi_sck` is low and both interrupt outputs are low.
- R2: With control bit 7 at 0, the word's bit 7 goes out first and the first bit received lands in bit 7. `spi_mosi` changes only when `spi_sck` falls, and it holds steady while `spi_sck` is high.
- R3: With control bit 7 at 1, the word's bit 0 goes out first and the first bit received lands in bit 0.
- R4: With control bit 5 at 0, `spi_cs_n` is driven low automatically. It falls 2 system clocks before the first rising `spi_sck` edge and rises 2 system clocks after the last falling edge. In queued mode it stays low across consecutive words for as long as the transmit queue holds data. While it is high, `spi_sck` is low.
- R5: With control bit 5 at 1, `spi_cs_n` equals control bit 6, including while a transfer is running.
- R6: A word that completes while the receive storage is full is dropped, and status bit 1 is set. The storage counts as full when it holds 1 word in direct mode or 8 words in queued mode. Status bit 1 stays set until software writes 1 to status bit 1. `irq_ovr` is status bit 1 AND control bit 3.
- R7: Status bit 0 is 1 exactly when the shifter is idle and no transmit word is waiting. `irq_txc` is status bit 0 AND control bit 4.
- R8: With control bit 8 at 1, up to 8 transmit words and 8 received words are held, in arrival order. With control bit 8 at 0, one word is held in each direction. A write to a full transmit store is dropped, and status bit 3 shows that the transmit store is full. Status bit 2 shows that received data is available, and status bits 11:8 give the receive count. Any write that changes control bit 8 empties both stores.
- R9: `spi_sck` runs at the system clock divided by 4: each high phase and each low phase lasts 2 clocks, each word takes exactly 8 rising edges, and rising edges within a chip-select window are 4 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 3 removes a word) |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 transmit, 3 receive |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| irq_txc | output | 1 | Transmit-complete interrupt |
| irq_ovr | output | 1 | Receive-overrun interrupt |

## Verification
The bench checks the first bit on the wire with the words 0x80 and 0x01 in both bit orders. A design that swaps the order, or that reverses only one direction, fails there. It writes three words to direct mode without pausing, so the third is dropped. It then lets two words arrive without a read, so the second is lost while the first stays readable. A design that overwrites the unread word or queues the extra one is caught. A burst of ten writes in queued mode fills the transmit queue and overflows the receive queue by one word. During that burst the chip select must stay low throughout and the clock edges must stay 4 cycles apart across word boundaries. A design that breaks the chip-select window between words, or that slips a half period between words, is caught. Switching mode with data waiting must empty the stores, and manual chip select must hold its level through a whole transfer.

// File: rtl/spi_pkg.sv
// Package: shared register addresses, control/status bit positions,
// the control register type and the shift engine state type.
package spi_pkg;

    // Register word addresses on the simple register port
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_TXD  = 2'd2;
    localparam logic [1:0] ADR_RXD  = 2'd3;

    // Control bit positions
    localparam int B_FIFO   = 8;
    localparam int B_LSB    = 7;
    localparam int B_CSVAL  = 6;
    localparam int B_CSMAN  = 5;
    localparam int B_TXCIE  = 4;
    localparam int B_OVRIE  = 3;

    // Status bit positions
    localparam int S_TXC    = 0;
    localparam int S_OVR    = 1;
    localparam int S_RXAV   = 2;
    localparam int S_TXFULL = 3;
    localparam int S_BUSY   = 4;
    localparam int S_LVL    = 8;

    typedef struct packed {
        logic fifo_en;
        logic lsb_first;
        logic cs_val;
        logic cs_manual;
        logic txc_ie;
        logic ovr_ie;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{fifo_en: 1'b0, lsb_first: 1'b0, cs_val: 1'b1,
                                   cs_manual: 1'b0, txc_ie: 1'b0, ovr_ie: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HI,
        ST_LO,
        ST_TRAIL
    } eng_state_t;

endpackage

// File: rtl/spi_qbuf.sv
// Module: spi_qbuf
// A first-in first-out store whose capacity is switched at run time.
// It holds DEPTH entries normally, or one entry when 'single' is high.
// Assumes: a push into a full store and a pop from an empty store are
// ignored, and flush takes priority over push and pop in the same cycle.
module spi_qbuf #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];
    assign level   = cnt;

    // Next pointer value with wrap for any depth
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
// Module: spi_shift_engine
// Serial shifter in clock mode 0. It takes a word from the transmit store,
// runs 8 serial clock periods of 2*HALF system clocks each, and hands the
// captured word to the receive store. Bit order is set by reversing the
// word at load and at unload, so the shift register always moves left.
// Assumes: lsb_first and fifo_mode stay stable while a word is in flight.
module spi_shift_engine
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              lsb_first,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              active
);
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    eng_state_t        st;
    logic [HCW-1:0]    hcnt;
    logic [BW-1:0]     bcnt;
    logic [DATA_W-1:0] tsh, rsh;
    logic [DATA_W-1:0] tx_rev, rx_rev, load_word;
    logic              half_end, last_bit, word_end, chain;

    // Bit reversal networks for the least-significant-first order
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign tx_rev[i] = tx_data[DATA_W-1-i];
        assign rx_rev[i] = rsh[DATA_W-1-i];
    end

    assign load_word = lsb_first ? tx_rev : tx_data;
    assign half_end  = (hcnt == HCW'(HALF-1));
    assign last_bit  = (bcnt == BW'(DATA_W-1));
    assign word_end  = (st == ST_HI) && half_end && last_bit;
    assign chain     = word_end && fifo_mode && tx_valid;

    assign tx_pop  = ((st == ST_IDLE) && tx_valid) || chain;
    assign rx_push = word_end;
    assign rx_data = lsb_first ? rx_rev : rsh;
    assign sck     = (st == ST_HI);
    assign mosi    = tsh[DATA_W-1];
    assign active  = (st != ST_IDLE);

    // Transfer sequencer: setup half, 8 high/low bit periods, trailing half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            hcnt <= '0;
            bcnt <= '0;
            tsh  <= '0;
            rsh  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    hcnt <= '0;
                    if (tx_valid) begin
                        tsh  <= load_word;
                        bcnt <= '0;
                        st   <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_LO: begin
                    if (half_end) begin
                        hcnt <= '0;
                        rsh  <= {rsh[DATA_W-2:0], miso};
                        st   <= ST_HI;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_HI: begin
                    if (half_end) begin
                        hcnt <= '0;
                        if (last_bit) begin
                            bcnt <= '0;
                            if (chain) begin
                                tsh <= load_word;
                                st  <= ST_LO;
                            end else begin
                                st  <= ST_TRAIL;
                            end
                        end else begin
                            tsh  <= {tsh[DATA_W-2:0], 1'b0};
                            bcnt <= bcnt + 1'b1;
                            st   <= ST_LO;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (half_end) begin
                        hcnt <= '0;
                        st   <= ST_IDLE;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_regs.sv
// Module: spi_regs
// Register file: control register, sticky overrun flag, status readback,
// and the strobes that feed the two stores. It also produces both
// interrupt outputs.
// Assumes: the read data path is combinational, and a read of the receive
// address pops the store in the same cycle.
module spi_regs
    import spi_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DATA_W = 8,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic              q_flush,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_wdata,
    output logic              rx_pop,
    input  logic              eng_active,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_head,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              ovr_flag,
    output logic              irq_txc,
    output logic              irq_ovr
);
    logic ctrl_wr, stat_wr, txc, ovr_event;
    logic unused_wbits;

    assign unused_wbits = ^wdata[REG_W-1:B_FIFO+1];
    assign ctrl_wr   = wr && (addr == ADR_CTRL);
    assign stat_wr   = wr && (addr == ADR_STAT);
    assign q_flush   = ctrl_wr && (wdata[B_FIFO] != ctrl.fifo_en);
    assign tx_push   = wr && (addr == ADR_TXD);
    assign tx_wdata  = wdata[DATA_W-1:0];
    assign rx_pop    = rd && (addr == ADR_RXD);
    assign ovr_event = rx_push && rx_full;
    assign txc       = !eng_active && tx_empty;
    assign irq_txc   = txc && ctrl.txc_ie;
    assign irq_ovr   = ovr_flag && ctrl.ovr_ie;

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl <= '{fifo_en:   wdata[B_FIFO],
                      lsb_first: wdata[B_LSB],
                      cs_val:    wdata[B_CSVAL],
                      cs_manual: wdata[B_CSMAN],
                      txc_ie:    wdata[B_TXCIE],
                      ovr_ie:    wdata[B_OVRIE]};
        end
    end

    // Sticky overrun flag; a new overrun wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (ovr_event) begin
            ovr_flag <= 1'b1;
        end else if (stat_wr && wdata[S_OVR]) begin
            ovr_flag <= 1'b0;
        end
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[B_FIFO]  = ctrl.fifo_en;
                rdata[B_LSB]   = ctrl.lsb_first;
                rdata[B_CSVAL] = ctrl.cs_val;
                rdata[B_CSMAN] = ctrl.cs_manual;
                rdata[B_TXCIE] = ctrl.txc_ie;
                rdata[B_OVRIE] = ctrl.ovr_ie;
            end
            ADR_STAT: begin
                rdata[S_TXC]            = txc;
                rdata[S_OVR]            = ovr_flag;
                rdata[S_RXAV]           = !rx_empty;
                rdata[S_TXFULL]         = tx_full;
                rdata[S_BUSY]           = eng_active;
                rdata[S_LVL +: LVL_W]   = rx_level;
            end
            ADR_RXD: rdata[DATA_W-1:0] = rx_head;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_master.sv
// Module: spi_fifo_master (top)
// Serial master with a register port, a transmit store and a receive
// store that switch between one word and FIFO_DEPTH words, a clock-mode-0
// shift engine, and chip select that is either automatic or forced.
// Assumes: CLK_DIV is even and at least 2, and REG_W leaves room for the
// control bits and the status level field.
module spi_fifo_master
    import spi_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_DIV    = 4,
    parameter int REG_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             irq_txc,
    output logic             irq_ovr
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);

    ctrl_t             ctrl_q;
    logic              q_flush, tx_push, rx_pop, eng_active;
    logic [DATA_W-1:0] tx_wdata, tx_head, rx_head, rx_word;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_pop, rx_push, ovr_flag;
    logic [LVL_W-1:0]  rx_level, tx_level_unused;

    spi_regs #(.REG_W(REG_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl_q), .q_flush(q_flush),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop),
        .eng_active(eng_active), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_push(rx_push),
        .rx_head(rx_head), .rx_level(rx_level), .ovr_flag(ovr_flag),
        .irq_txc(irq_txc), .irq_ovr(irq_ovr)
    );

    spi_qbuf #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(q_flush), .single(!ctrl_q.fifo_en),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level_unused)
    );

    spi_qbuf #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(q_flush), .single(!ctrl_q.fifo_en),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .HALF(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .fifo_mode(ctrl_q.fifo_en),
        .lsb_first(ctrl_q.lsb_first), .tx_valid(!tx_empty), .tx_data(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .active(eng_active)
    );

    // Chip select: forced level in manual mode, else low while shifting
    assign spi_cs_n = ctrl_q.cs_manual ? ctrl_q.cs_val : !eng_active;

endmodule

// File: rtl/spi_master_chk.sv
// Module: spi_master_chk
// Property checker bound into spi_fifo_master. It watches the serial pins,
// the control mode bits, the receive level and the sticky overrun flag.
module spi_master_chk
    import spi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck,
    input logic             mosi,
    input logic             cs_n,
    input logic             cs_manual,
    input logic             fifo_en,
    input logic [LVL_W-1:0] rx_level,
    input logic             ovr_flag,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             clr_bit
);
    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_manual && cs_n) |-> !sck); // R4

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R2

    AST_SCK_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> sck); // R9

    AST_SCK_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |=> !sck); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(DEPTH)); // R8

    AST_DIRECT_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_level <= LVL_W'(1))); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(reg_wr && reg_addr == ADR_STAT && clr_bit)) |=> ovr_flag); // R6

endmodule

bind spi_fifo_master spi_master_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .cs_manual(ctrl_q.cs_manual), .fifo_en(ctrl_q.fifo_en), .rx_level(rx_level),
    .ovr_flag(ovr_flag), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .clr_bit(reg_wdata[1])
);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso, spi_cs_n, irq_txc, irq_ovr;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq_txc(irq_txc), .irq_ovr(irq_ovr)
    );

    // Slave model: presents slv_words[sidx] and records what the master sends
    logic [7:0] slv_words [0:255];
    logic [7:0] mrx [0:255];
    int         sidx = 0, scnt = 0, mrx_n = 0;
    logic       slv_lsb = 1'b0;
    logic [7:0] rsh = 8'd0;

    assign spi_miso = slv_lsb ? slv_words[sidx[7:0]][scnt[2:0]]
                              : slv_words[sidx[7:0]][3'd7 - scnt[2:0]];

    always @(posedge spi_sck) begin
        rsh = slv_lsb ? {spi_mosi, rsh[7:1]} : {rsh[6:0], spi_mosi};
        scnt++;
        if (scnt == 8) begin
            mrx[mrx_n[7:0]] = rsh;
            mrx_n++;
        end
    end

    always @(negedge spi_sck) begin
        if (scnt == 8) begin
            scnt = 0;
            sidx++;
        end
    end

    // Timing monitor for the automatic chip select and the clock period
    int   cyc = 0, cs_fall_cyc = 0, last_rise = 0, last_fall = 0;
    int   lead_bad = 0, gap_bad = 0, trail_bad = 0, rises = 0, cs_rises = 0;
    bit   first_rise = 1'b0, mon_on = 1'b1;
    logic sck_p = 1'b0, cs_p = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && mon_on) begin
            if (cs_p && !spi_cs_n) begin
                cs_fall_cyc = cyc;
                first_rise  = 1'b1;
            end
            if (spi_sck && !sck_p) begin
                rises++;
                if (first_rise) begin
                    if (cyc - cs_fall_cyc != 2) lead_bad++;
                    first_rise = 1'b0;
                end else if (cyc - last_rise != 4) begin
                    gap_bad++;
                end
                last_rise = cyc;
            end
            if (!spi_sck && sck_p) last_fall = cyc;
            if (!cs_p && spi_cs_n) begin
                cs_rises++;
                if (cyc - last_fall != 2) trail_bad++;
            end
        end
        sck_p = spi_sck;
        cs_p  = spi_cs_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int n = 0;
        do begin
            rd(2'd1, s);
            n++;
        end while (!s[0] && n < 3000);
    endtask

    // Control value built from the bench's view of the bit layout
    function automatic logic [15:0] ctl(input bit fifo, input bit lsb, input bit csv,
                                        input bit man, input bit tie, input bit oie);
        return {7'd0, fifo, lsb, csv, man, tie, oie, 3'd0};
    endfunction

    // One direct-mode transfer with both directions compared
    task automatic xfer_direct(input logic [7:0] w, input bit lsb, input string req);
        logic [15:0] got;
        int t = mrx_n;
        slv_lsb = lsb;
        wr(2'd0, ctl(0, lsb, 1, 0, 0, 0));
        wr(2'd2, {8'd0, w});
        wait_idle();
        rd(2'd3, got);
        chk(req, {24'd0, mrx[t[7:0]]}, {24'd0, w});
        chk(req, {16'd0, got}, {24'd0, slv_words[t[7:0]]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] s, got;
        logic [7:0]  wq [0:9];
        int          t0, c0, n;
        bit          lsb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) slv_words[i] = 8'($urandom);

        repeat (5) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, s); chk("R1 ctrl", {16'd0, s}, 32'h0040);
        rd(2'd1, s); chk("R1 status", {16'd0, s}, 32'h0001);
        chk("R1 cs_n", {31'd0, spi_cs_n}, 1);
        chk("R1 sck", {31'd0, spi_sck}, 0);
        chk("R1 irq", {30'd0, irq_txc, irq_ovr}, 0);

        // R2 and R3 directed first-bit cases
        xfer_direct(8'h80, 0, "R2 msb 80");
        xfer_direct(8'h01, 0, "R2 msb 01");
        xfer_direct(8'h01, 1, "R3 lsb 01");
        xfer_direct(8'h80, 1, "R3 lsb 80");

        // Random direct transfers, random order
        for (int k = 0; k < 16; k++) begin
            lsb = 1'($urandom);
            xfer_direct(8'($urandom), lsb, lsb ? "R3 random" : "R2 random");
        end

        // R8 and R6: direct mode holds one word each way
        slv_lsb = 1'b0;
        wr(2'd0, ctl(0, 0, 1, 0, 0, 1));
        t0 = mrx_n;
        wr(2'd2, 16'h00A5);
        wr(2'd2, 16'h003C);
        wr(2'd2, 16'h00FF);
        wait_idle();
        chk("R8 direct tx drop count", mrx_n - t0, 2);
        chk("R8 direct word0", {24'd0, mrx[t0[7:0]]}, 32'hA5);
        chk("R8 direct word1", {24'd0, mrx[8'(t0 + 1)]}, 32'h3C);
        rd(2'd1, s);
        chk("R6 overrun flag", {31'd0, s[1]}, 1);
        chk("R6 irq_ovr enabled", {31'd0, irq_ovr}, 1);
        rd(2'd3, got);
        chk("R6 first word kept", {16'd0, got}, {24'd0, slv_words[t0[7:0]]});
        wr(2'd0, ctl(0, 0, 1, 0, 0, 0));
        chk("R6 irq_ovr disabled", {31'd0, irq_ovr}, 0);
        rd(2'd1, s);
        chk("R6 flag sticky", {31'd0, s[1]}, 1);
        wr(2'd1, 16'h0002);
        rd(2'd1, s);
        chk("R6 flag cleared", {31'd0, s[1]}, 0);

        // R7 transmit-complete interrupt
        wr(2'd0, ctl(0, 0, 1, 0, 1, 0));
        chk("R7 irq idle", {31'd0, irq_txc}, 1);
        wr(2'd2, 16'h005A);
        chk("R7 irq busy", {31'd0, irq_txc}, 0);
        wait_idle();
        chk("R7 irq done", {31'd0, irq_txc}, 1);
        rd(2'd3, got);

        // R4 and R9 timing so far in automatic mode
        chk("R4 lead", lead_bad, 0);
        chk("R4 trail", trail_bad, 0);
        chk("R9 period", gap_bad, 0);
        chk("R9 rises per word", rises, 8 * mrx_n);

        // R5 manual chip select
        mon_on = 1'b0;
        wr(2'd0, ctl(0, 0, 0, 1, 0, 0));
        chk("R5 forced low", {31'd0, spi_cs_n}, 0);
        t0 = mrx_n;
        wr(2'd2, 16'h00C6);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (spi_cs_n !== 1'b0) n++;
        end
        wait_idle();
        chk("R5 low through transfer", n, 0);
        chk("R5 data", {24'd0, mrx[t0[7:0]]}, 32'hC6);
        rd(2'd3, got);
        wr(2'd0, ctl(0, 0, 1, 1, 0, 0));
        chk("R5 forced high", {31'd0, spi_cs_n}, 1);
        wr(2'd0, ctl(0, 0, 1, 0, 0, 0));
        mon_on = 1'b1;

        // R8 queued mode burst: fills transmit, overflows receive by one
        wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
        t0 = mrx_n;
        c0 = cs_rises;
        for (int i = 0; i < 10; i++) begin
            wq[i] = 8'($urandom);
            wr(2'd2, {8'd0, wq[i]});
        end
        rd(2'd1, s);
        chk("R8 tx full", {31'd0, s[3]}, 1);
        wait_idle();
        chk("R8 tx count", mrx_n - t0, 9);
        for (int i = 0; i < 9; i++)
            chk("R8 tx order", {24'd0, mrx[8'(t0 + i)]}, {24'd0, wq[i]});
        chk("R4 one window", cs_rises - c0, 1);
        chk("R9 burst period", gap_bad, 0);
        rd(2'd1, s);
        chk("R6 queue overrun", {31'd0, s[1]}, 1);
        chk("R8 rx level", {28'd0, s[11:8]}, 8);
        for (int i = 0; i < 8; i++) begin
            rd(2'd3, got);
            chk("R8 rx order", {16'd0, got}, {24'd0, slv_words[8'(t0 + i)]});
        end
        rd(2'd1, s);
        chk("R8 rx drained", {31'd0, s[2]}, 0);
        wr(2'd1, 16'h0002);

        // Random queued bursts, random order
        for (int b = 0; b < 3; b++) begin
            lsb = 1'($urandom);
            slv_lsb = lsb;
            wr(2'd0, ctl(1, lsb, 1, 0, 0, 0));
            n = 1 + int'($urandom % 8);
            t0 = mrx_n;
            for (int i = 0; i < n; i++) begin
                wq[i] = 8'($urandom);
                wr(2'd2, {8'd0, wq[i]});
            end
            wait_idle();
            for (int i = 0; i < n; i++) begin
                rd(2'd3, got);
                chk(lsb ? "R3 burst tx" : "R2 burst tx", {24'd0, mrx[8'(t0 + i)]}, {24'd0, wq[i]});
                chk("R8 burst rx", {16'd0, got}, {24'd0, slv_words[8'(t0 + i)]});
            end
        end

        // R8 mode change empties the stores
        slv_lsb = 1'b0;
        wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
        wr(2'd2, 16'h0011);
        wr(2'd2, 16'h0022);
        wait_idle();
        rd(2'd1, s);
        chk("R8 level before switch", {28'd0, s[11:8]}, 2);
        wr(2'd0, ctl(0, 0, 1, 0, 0, 0));
        rd(2'd1, s);
        chk("R8 flushed avail", {31'd0, s[2]}, 0);
        chk("R8 flushed level", {28'd0, s[11:8]}, 0);
        chk("R4 final trail", trail_bad, 0);
        chk("R4 final lead", lead_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule